// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block holds a parameterised set of wide event counters behind a small word-wide register port. Each counter picks one of several event inputs with a condition code. When the global run bit is set, the counter advances by one on every clock in which its chosen event is high. A mode filter can limit counting to kernel or to user privilege. Code zero never matches, so it parks the counter. There is no other per-counter start or stop control.

Software first writes an index register. From then on, the per-counter registers act on the counter that the index names: condition, count halves, snapshot halves and threshold halves. Software writes the control register with the capture bit set to freeze the counter's full value into its snapshot. It can then read the two snapshot halves one after the other without a carry slipping between them.

Each counter has an interrupt-enable bit and an interrupt-active bit. An enabled counter raises its active bit when an increment lands exactly on its threshold. The single interrupt line is high while any counter is both active and enabled. Clearing an active bit by writing a one also clears that counter's enable bit.

Top module: `evctr_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map on `bus_addr`: 0 control, 1 index, 2 condition, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 threshold low, 8 threshold high, 9 interrupt enable, 10 interrupt active. Other addresses read 0. Registers 2 to 8 act only on the counter named by the index (index field bits 4:0).
- R3: Control bit 0 is the run bit. While it is 0, no counter changes except through a count write.
- R4: Condition bits 7:0 hold the code. Code c in 1..NUM_COND selects `ev_in[c-1]`. Code 0, and any code above NUM_COND, never counts.
- R5: Condition bit 8 limits counting to `priv_kern`=1, and bit 9 limits it to `priv_kern`=0. With both bits set or both clear, counting happens in either mode.
- R6: A count-low write loads bits 31:0 and a count-high write loads bits CW-1:32 (CW = 32+16×CTR_EXT). A count write in the same cycle as an increment wins. The counter wraps from all ones to zero.
- R7: A control write with bit 1 set copies the selected counter's value from before that edge into its snapshot. The snapshot then stays fixed until the next capture.
- R8: An increment whose result equals the threshold sets the counter's active bit, but only if its enable bit was set before that edge.
- R9: `irq` is high exactly when some counter has both its active bit and its enable bit set.
- R10: Writing a 1 to a bit of the active register clears that active bit and the same enable bit. A threshold hit in the same cycle still sets the active bit.
- R11: An index at or above NUM_CTR selects nothing. Writes to registers 2 to 8 are then ignored and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | NUM_COND | Event condition inputs |
| priv_kern | input | 1 | Current mode: 1 kernel, 0 user |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Counter interrupt |

## Verification
The hardest cases to reach from the ports are a threshold hit that coincides with a wrap, and a hit that lands on the same edge as a write-one-to-clear or a count load. Reaching them by plain counting would take about 2^48 cycles. The stimulus instead loads counters and thresholds with values a few steps apart, or with all-ones and a zero threshold. It then runs a long random phase of small loads, small thresholds, random writes and random event and mode inputs. A behavioural model in the bench follows every edge, and the bench compares `irq` and a register read on every clock.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    typedef enum logic [3:0] {
        RA_CTRL    = 4'd0,
        RA_INDEX   = 4'd1,
        RA_COND    = 4'd2,
        RA_CNT_LO  = 4'd3,
        RA_CNT_HI  = 4'd4,
        RA_SNAP_LO = 4'd5,
        RA_SNAP_HI = 4'd6,
        RA_THR_LO  = 4'd7,
        RA_THR_HI  = 4'd8,
        RA_IEN     = 4'd9,
        RA_IACT    = 4'd10
    } reg_addr_e;

    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_SNAP_BIT = 1;
    localparam int unsigned INDEX_W       = 5;
    localparam int unsigned COND_W        = 10;

    typedef struct packed {
        logic       user_only;
        logic       kern_only;
        logic [7:0] code;
    } cond_cfg_t;

endpackage

// File: rtl/evctr_event_gate.sv
module evctr_event_gate
    import evctr_pkg::*;
#(
    parameter int unsigned NUM_COND = 6
) (
    input  cond_cfg_t           cfg,
    input  logic [NUM_COND-1:0] ev_in,
    input  logic                priv_kern,
    input  logic                run,
    output logic                fire
);

    logic ev_pick;
    logic mode_ok;

    always_comb begin
        ev_pick = 1'b0;
        for (int c = 0; c < NUM_COND; c++) begin
            if (cfg.code == 8'(c + 1)) ev_pick = ev_in[c];
        end
        if (cfg.kern_only == cfg.user_only) mode_ok = 1'b1;
        else if (cfg.kern_only)             mode_ok = priv_kern;
        else                                mode_ok = ~priv_kern;
        fire = run & ev_pick & mode_ok;
    end

endmodule

// File: rtl/evctr_slot.sv
module evctr_slot
    import evctr_pkg::*;
#(
    parameter int unsigned CW       = 48,
    parameter int unsigned NUM_COND = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [NUM_COND-1:0] ev_in,
    input  logic                priv_kern,
    input  logic                we_cond,
    input  logic                we_cnt_lo,
    input  logic                we_cnt_hi,
    input  logic                we_thr_lo,
    input  logic                we_thr_hi,
    input  logic                take_snap,
    input  logic [31:0]         wdata,
    input  logic                ien_we,
    input  logic                ien_wval,
    input  logic                iact_clr,
    output cond_cfg_t           cfg_q,
    output logic [CW-1:0]       cnt_q,
    output logic [CW-1:0]       thr_q,
    output logic [CW-1:0]       snap_q,
    output logic                ien_q,
    output logic                iact_q
);

    localparam int unsigned HW = CW - 32;

    logic          fire;
    logic          cnt_wr;
    logic          hit;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] thr_d;

    evctr_event_gate #(.NUM_COND(NUM_COND)) u_gate (
        .cfg       (cfg_q),
        .ev_in     (ev_in),
        .priv_kern (priv_kern),
        .run       (run),
        .fire      (fire)
    );

    always_comb begin
        cnt_inc = cnt_q + CW'(1);
        cnt_wr  = we_cnt_lo | we_cnt_hi;
        cnt_d   = cnt_q;
        if (we_cnt_lo)      cnt_d[31:0]    = wdata;
        else if (we_cnt_hi) cnt_d[CW-1:32] = wdata[HW-1:0];
        else if (fire)      cnt_d          = cnt_inc;
        thr_d = thr_q;
        if (we_thr_lo)      thr_d[31:0]    = wdata;
        else if (we_thr_hi) thr_d[CW-1:32] = wdata[HW-1:0];
        hit = fire & ~cnt_wr & ien_q & (cnt_inc == thr_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            thr_q  <= '0;
            snap_q <= '0;
            ien_q  <= 1'b0;
            iact_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            thr_q <= thr_d;
            if (we_cond)   cfg_q  <= cond_cfg_t'(wdata[COND_W-1:0]);
            if (take_snap) snap_q <= cnt_q;
            if (iact_clr)    ien_q <= 1'b0;
            else if (ien_we) ien_q <= ien_wval;
            iact_q <= hit | (iact_q & ~iact_clr);
        end
    end

endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int unsigned NUM_CTR  = 4,
    parameter int unsigned NUM_COND = 6,
    parameter int unsigned CTR_EXT  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] ev_in,
    input  logic                priv_kern,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq
);

    localparam int unsigned CW   = 32 + 16 * CTR_EXT;
    localparam int unsigned IDXW = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    reg_addr_e                   ra;
    logic                        run_q;
    logic [INDEX_W-1:0]          sel_q;
    logic                        sel_ok;
    logic [IDXW-1:0]             sel_idx;
    logic                        wr_ctrl, wr_index, wr_cond, wr_cnt_lo, wr_cnt_hi;
    logic                        wr_thr_lo, wr_thr_hi, wr_ien, wr_iact;
    cond_cfg_t [NUM_CTR-1:0]     cfg_a;
    logic [NUM_CTR-1:0][CW-1:0]  cnt_a;
    logic [NUM_CTR-1:0][CW-1:0]  thr_a;
    logic [NUM_CTR-1:0][CW-1:0]  snap_a;
    logic [NUM_CTR-1:0]          ien_v;
    logic [NUM_CTR-1:0]          iact_v;
    cond_cfg_t                   cfg_sel;
    logic [CW-1:0]               cnt_sel, thr_sel, snap_sel;

    assign ra        = reg_addr_e'(bus_addr);
    assign wr_ctrl   = bus_wr && (ra == RA_CTRL);
    assign wr_index  = bus_wr && (ra == RA_INDEX);
    assign wr_cond   = bus_wr && (ra == RA_COND);
    assign wr_cnt_lo = bus_wr && (ra == RA_CNT_LO);
    assign wr_cnt_hi = bus_wr && (ra == RA_CNT_HI);
    assign wr_thr_lo = bus_wr && (ra == RA_THR_LO);
    assign wr_thr_hi = bus_wr && (ra == RA_THR_HI);
    assign wr_ien    = bus_wr && (ra == RA_IEN);
    assign wr_iact   = bus_wr && (ra == RA_IACT);

    assign sel_ok  = (32'(sel_q) < NUM_CTR);
    assign sel_idx = sel_q[IDXW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            sel_q <= '0;
        end else begin
            if (wr_ctrl)  run_q <= bus_wdata[CTRL_RUN_BIT];
            if (wr_index) sel_q <= bus_wdata[INDEX_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        logic own;
        assign own = sel_ok && (sel_q == INDEX_W'(i));

        evctr_slot #(.CW(CW), .NUM_COND(NUM_COND)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_q),
            .ev_in     (ev_in),
            .priv_kern (priv_kern),
            .we_cond   (wr_cond & own),
            .we_cnt_lo (wr_cnt_lo & own),
            .we_cnt_hi (wr_cnt_hi & own),
            .we_thr_lo (wr_thr_lo & own),
            .we_thr_hi (wr_thr_hi & own),
            .take_snap (wr_ctrl & bus_wdata[CTRL_SNAP_BIT] & own),
            .wdata     (bus_wdata),
            .ien_we    (wr_ien),
            .ien_wval  (bus_wdata[i]),
            .iact_clr  (wr_iact & bus_wdata[i]),
            .cfg_q     (cfg_a[i]),
            .cnt_q     (cnt_a[i]),
            .thr_q     (thr_a[i]),
            .snap_q    (snap_a[i]),
            .ien_q     (ien_v[i]),
            .iact_q    (iact_v[i])
        );
    end

    assign irq = |(iact_v & ien_v);

    always_comb begin
        cfg_sel  = sel_ok ? cfg_a[sel_idx]  : '0;
        cnt_sel  = sel_ok ? cnt_a[sel_idx]  : '0;
        thr_sel  = sel_ok ? thr_a[sel_idx]  : '0;
        snap_sel = sel_ok ? snap_a[sel_idx] : '0;
        case (ra)
            RA_CTRL:    bus_rdata = 32'(run_q);
            RA_INDEX:   bus_rdata = 32'(sel_q);
            RA_COND:    bus_rdata = 32'(cfg_sel);
            RA_CNT_LO:  bus_rdata = cnt_sel[31:0];
            RA_CNT_HI:  bus_rdata = 32'(cnt_sel[CW-1:32]);
            RA_SNAP_LO: bus_rdata = snap_sel[31:0];
            RA_SNAP_HI: bus_rdata = 32'(snap_sel[CW-1:32]);
            RA_THR_LO:  bus_rdata = thr_sel[31:0];
            RA_THR_HI:  bus_rdata = 32'(thr_sel[CW-1:32]);
            RA_IEN:     bus_rdata = 32'(ien_v);
            RA_IACT:    bus_rdata = 32'(iact_v);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evctr_bank_chk.sv
module evctr_bank_chk #(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned CW      = 48,
    parameter int unsigned IDXW    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [3:0]                 bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [4:0]                 sel_q,
    input logic                       run_q,
    input logic [NUM_CTR-1:0][CW-1:0] cnt_a,
    input logic [NUM_CTR-1:0][CW-1:0] snap_a,
    input logic [NUM_CTR-1:0]         ien_v,
    input logic [NUM_CTR-1:0]         iact_v,
    input logic                       irq
);

    logic sel_ok;
    logic cnt_write;
    assign sel_ok    = (32'(sel_q) < NUM_CTR);
    assign cnt_write = bus_wr && (bus_addr == 4'd3 || bus_addr == 4'd4);

    assert_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cnt_a == '0 && iact_v == '0 && !irq));

    assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_write) |=> $stable(cnt_a));

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3 && sel_ok)
        |=> cnt_a[$past(sel_q[IDXW-1:0])][31:0] == $past(bus_wdata));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd0 && bus_wdata[1] && sel_ok)
        |=> snap_a[$past(sel_q[IDXW-1:0])] == $past(cnt_a[sel_q[IDXW-1:0]]));

    assert_set_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (iact_v & ~$past(iact_v) & ~$past(ien_v)) == '0);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iact_v == '0 || ien_v == '0) |-> !irq);

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd10)
        |=> (ien_v & $past(bus_wdata[NUM_CTR-1:0])) == '0);

endmodule

bind evctr_bank evctr_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CW      (CW),
    .IDXW    (IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .run_q     (run_q),
    .cnt_a     (cnt_a),
    .snap_a    (snap_a),
    .ien_v     (ien_v),
    .iact_v    (iact_v),
    .irq       (irq)
);

// File: tb/test_evctr_bank.sv
module test_evctr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCTR  = 4;
    localparam int NCOND = 6;
    localparam int CW    = 48;
    localparam logic [63:0] MASK = (64'd1 << CW) - 64'd1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCOND-1:0] ev = '0;
    logic             priv = 1'b0;
    logic             wr = 1'b0;
    logic [3:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_run;
    logic [4:0]  m_sel;
    logic [7:0]  m_code [NCTR];
    logic        m_ko   [NCTR];
    logic        m_uo   [NCTR];
    logic [63:0] m_cnt  [NCTR];
    logic [63:0] m_thr  [NCTR];
    logic [63:0] m_snap [NCTR];
    logic [NCTR-1:0] m_ien;
    logic [NCTR-1:0] m_iact;

    evctr_bank #(.NUM_CTR(NCTR), .NUM_COND(NCOND), .CTR_EXT(1)) i_evctr_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_in     (ev),
        .priv_kern (priv),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_run = 1'b0; m_sel = '0; m_ien = '0; m_iact = '0;
        for (int i = 0; i < NCTR; i++) begin
            m_code[i] = '0; m_ko[i] = 1'b0; m_uo[i] = 1'b0;
            m_cnt[i] = '0; m_thr[i] = '0; m_snap[i] = '0;
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        bit ok;
        int s;
        ok = (m_sel < NCTR);
        s  = ok ? int'(m_sel) : 0;
        case (a)
            4'd0:  return {31'b0, m_run};
            4'd1:  return {27'b0, m_sel};
            4'd2:  return ok ? {22'b0, m_uo[s], m_ko[s], m_code[s]} : 32'b0;
            4'd3:  return ok ? m_cnt[s][31:0]   : 32'b0;
            4'd4:  return ok ? m_cnt[s][63:32]  : 32'b0;
            4'd5:  return ok ? m_snap[s][31:0]  : 32'b0;
            4'd6:  return ok ? m_snap[s][63:32] : 32'b0;
            4'd7:  return ok ? m_thr[s][31:0]   : 32'b0;
            4'd8:  return ok ? m_thr[s][63:32]  : 32'b0;
            4'd9:  return {28'b0, m_ien};
            4'd10: return {28'b0, m_iact};
            default: return 32'b0;
        endcase
    endfunction

    task automatic model_step();
        logic [NCTR-1:0] fire;
        logic [NCTR-1:0] wrote;
        logic [NCTR-1:0] setb;
        logic [NCTR-1:0] ien_old;
        logic [63:0]     thr_old [NCTR];
        bit ok;
        int s;
        ok = (m_sel < NCTR);
        s  = ok ? int'(m_sel) : 0;
        wrote = '0; setb = '0; ien_old = m_ien;
        for (int i = 0; i < NCTR; i++) begin
            bit e, md;
            thr_old[i] = m_thr[i];
            e  = (m_code[i] >= 1 && m_code[i] <= NCOND) ? ev[m_code[i] - 1] : 1'b0;
            md = (m_ko[i] == m_uo[i]) ? 1'b1 : (m_ko[i] ? priv : !priv);
            fire[i] = m_run && e && md;
        end
        if (wr) begin
            case (addr)
                4'd0: begin
                    if (wdata[1] && ok) m_snap[s] = m_cnt[s];
                    m_run = wdata[0];
                end
                4'd1: m_sel = wdata[4:0];
                4'd2: if (ok) begin
                    m_code[s] = wdata[7:0]; m_ko[s] = wdata[8]; m_uo[s] = wdata[9];
                end
                4'd3: if (ok) begin
                    m_cnt[s] = {m_cnt[s][63:32], wdata}; wrote[s] = 1'b1;
                end
                4'd4: if (ok) begin
                    m_cnt[s] = {wdata, m_cnt[s][31:0]} & MASK; wrote[s] = 1'b1;
                end
                4'd7: if (ok) m_thr[s] = {m_thr[s][63:32], wdata};
                4'd8: if (ok) m_thr[s] = {wdata, m_thr[s][31:0]} & MASK;
                4'd9: m_ien = wdata[NCTR-1:0];
                4'd10: begin
                    m_iact = m_iact & ~wdata[NCTR-1:0];
                    m_ien  = m_ien  & ~wdata[NCTR-1:0];
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NCTR; i++) begin
            if (fire[i] && !wrote[i]) begin
                m_cnt[i] = (m_cnt[i] + 64'd1) & MASK;
                if (ien_old[i] && m_cnt[i] == thr_old[i]) setb[i] = 1'b1;
            end
        end
        m_iact = m_iact | setb;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R9 irq", {31'b0, irq}, {31'b0, |(m_iact & m_ien)});
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        wr = 1'b0; addr = a;
        #1;
        check(tag, rdata, model_read(a));
    endtask

    task automatic rd_lit(input logic [3:0] a, input logic [31:0] exp, input string tag);
        wr = 1'b0; addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a <= 11; a++) rd_chk(4'(a), "R1 reset");
        check("R1 irq", {31'b0, irq}, 32'd0);

        // R2: index selection
        wr_reg(4'd1, 0); wr_reg(4'd3, 32'h11);
        wr_reg(4'd1, 2); wr_reg(4'd3, 32'h22);
        rd_lit(4'd3, 32'h22, "R2 index2");
        wr_reg(4'd1, 0);
        rd_lit(4'd3, 32'h11, "R2 index0");

        // R6: full load, wrap, write priority
        wr_reg(4'd1, 1); wr_reg(4'd3, 32'hFFFF_FFFF); wr_reg(4'd4, 32'hFFFF);
        rd_lit(4'd4, 32'hFFFF, "R6 high load");
        wr_reg(4'd2, 1);
        ev = 6'b000001;
        wr_reg(4'd0, 1);
        tick();
        rd_lit(4'd3, 32'h0, "R6 wrap low");
        rd_lit(4'd4, 32'h0, "R6 wrap high");
        wr_reg(4'd3, 5);
        rd_lit(4'd3, 32'd5, "R6 write over increment");
        tick();
        rd_lit(4'd3, 32'd6, "R6 count after load");

        // R3: run bit
        wr_reg(4'd0, 0);
        repeat (3) tick();
        rd_lit(4'd3, 32'd7, "R3 halted");

        // R4: condition codes
        wr_reg(4'd0, 1); wr_reg(4'd2, 0);
        repeat (3) tick();
        rd_chk(4'd3, "R4 code zero holds");
        wr_reg(4'd2, 7);
        repeat (3) tick();
        rd_chk(4'd3, "R4 code above range");
        wr_reg(4'd2, 3);
        repeat (2) tick();
        rd_chk(4'd3, "R4 other event low");
        ev = 6'b000100;
        repeat (4) tick();
        rd_chk(4'd3, "R4 event three");

        // R5: mode filters
        ev = 6'b000001; priv = 1'b0;
        wr_reg(4'd2, 32'h101);
        repeat (3) tick();
        rd_chk(4'd3, "R5 kernel only in user");
        priv = 1'b1;
        repeat (3) tick();
        rd_chk(4'd3, "R5 kernel only in kernel");
        wr_reg(4'd2, 32'h201);
        repeat (3) tick();
        rd_chk(4'd3, "R5 user only in kernel");
        priv = 1'b0;
        repeat (3) tick();
        rd_chk(4'd3, "R5 user only in user");
        wr_reg(4'd2, 32'h301);
        repeat (2) tick();
        rd_chk(4'd3, "R5 both bits");

        // R7: snapshot
        wr_reg(4'd0, 3);
        rd_chk(4'd5, "R7 snap low");
        rd_chk(4'd6, "R7 snap high");
        repeat (4) tick();
        rd_chk(4'd5, "R7 snap stable");
        rd_chk(4'd3, "R7 count moved on");

        // R8, R9, R10: threshold interrupt
        wr_reg(4'd1, 2);
        wr_reg(4'd7, 32'h26); wr_reg(4'd8, 0);
        wr_reg(4'd9, 32'b0100);
        wr_reg(4'd2, 1);
        repeat (6) tick();
        rd_chk(4'd10, "R8 active set");
        check("R9 irq raised", {31'b0, irq}, 32'd1);
        wr_reg(4'd10, 32'b0100);
        rd_chk(4'd10, "R10 active cleared");
        rd_chk(4'd9, "R10 enable cleared");
        wr_reg(4'd3, 0); wr_reg(4'd7, 3);
        repeat (6) tick();
        rd_lit(4'd10, 32'h0, "R8 disabled no set");

        // R11: out-of-range index
        wr_reg(4'd1, 5);
        wr_reg(4'd3, 32'h99); wr_reg(4'd2, 1);
        rd_lit(4'd3, 32'h0, "R11 read zero");
        wr_reg(4'd1, 1);
        rd_chk(4'd3, "R11 counter untouched");
        rd_chk(4'd2, "R11 cond untouched");

        // random phase with model compare on every clock
        for (int n = 0; n < 4000; n++) begin
            logic [3:0]  a;
            logic [31:0] d;
            ev   = NCOND'($urandom);
            priv = 1'($urandom);
            a = 4'($urandom_range(0, 11));
            d = $urandom;
            case (a)
                4'd0:      d = {30'b0, 2'($urandom)} | 32'd1;
                4'd1:      d = 32'($urandom_range(0, 5));
                4'd2:      d = {22'b0, 2'($urandom), 8'($urandom_range(0, 7))};
                4'd3, 4'd7: d = 32'($urandom_range(0, 40));
                4'd4, 4'd8: d = ($urandom_range(0, 7) == 0) ? 32'h0000_FFFF : 32'd0;
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0) wr_reg(a, d);
            else tick();
            rd_chk(4'($urandom_range(0, 11)), "R2 random read");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule